// File: doc/BRIEF.md
# Front Panel Operation Sequencer

This controller sits between the debounced switch events of a computer front panel and the hardware that carries out panel work. Each switch event is a single-cycle pulse. The controller turns the event into a fixed, ordered train of one-cycle command pulses. These pulses drive an address register (load from switches, increment) and a data workspace (load from the data bus, deposit to memory). The controller also drives the processor's reset line, its clock enable and a single-step pulse.

Compound commands are spread out in time. A configurable number of idle cycles separates successive pulses, so each downstream register settles before the next step. While a train is running, a busy flag is raised and further panel events are dropped rather than queued. While the processor clock runs, the controls that touch memory or stepping are locked out. Only processor reset and run/halt stay live.

Top module: `fpanel_seq`

## Requirements
- R1: An examine event while halted gives `cmd_load_addr` in the first cycle after the sampling edge, then `cmd_load_data` GAP+1 cycles later.
- R2: An examine-next event while halted gives `cmd_inc_addr` first, then `cmd_load_data` GAP+1 cycles later.
- R3: A deposit event while halted gives exactly one `cmd_deposit` pulse, in the first cycle after the sampling edge.
- R4: A deposit-next event while halted gives `cmd_deposit`, `cmd_inc_addr` and `cmd_load_data`, in that order, spaced GAP+1 cycles apart.
- R5: Every command pulse lasts one cycle. At most one of the five pulse outputs is high in any cycle. Exactly GAP idle cycles separate consecutive pulses of a train (default GAP = 1).
- R6: `busy` is high from the cycle of the first pulse through the cycle after the last pulse. While `busy` is high, every event except processor reset is ignored and is not queued.
- R7: A run/halt event toggles `cpu_clk_en` from the cycle after the sampling edge. It is ignored while `busy` or `cpu_reset` is high.
- R8: While `cpu_clk_en` is high, step, examine, examine-next, deposit and deposit-next events are ignored.
- R9: A step event while halted gives exactly one single-cycle `cpu_step` pulse, in the first cycle after the sampling edge, with `busy` high for that cycle and the next.
- R10: A processor-reset event is accepted in run and halt, and also during a train, which it cancels. `cpu_reset` is then high for max(RESET_CYCLES,4) consecutive cycles, starting the cycle after the sampling edge. `cpu_clk_en` is left unchanged. All events are ignored while `cpu_reset` is high.
- R11: When several events arrive in the same cycle, only one is taken. The priority, highest first, is: processor reset, run/halt, step, examine, examine-next, deposit, deposit-next.
- R12: A synchronous active-high `rst` drives all outputs low and leaves the block halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_reset | input | 1 | Processor reset switch event |
| ev_runhalt | input | 1 | Run/halt switch event |
| ev_step | input | 1 | Single-step switch event |
| ev_exam | input | 1 | Examine switch event |
| ev_exam_next | input | 1 | Examine-next switch event |
| ev_deposit | input | 1 | Deposit switch event |
| ev_deposit_next | input | 1 | Deposit-next switch event |
| cmd_load_addr | output | 1 | Pulse: load address register from switches |
| cmd_inc_addr | output | 1 | Pulse: increment address register |
| cmd_load_data | output | 1 | Pulse: copy data bus into the workspace |
| cmd_deposit | output | 1 | Pulse: drive workspace onto bus and write memory |
| cpu_reset | output | 1 | Processor reset, held for several cycles |
| cpu_clk_en | output | 1 | Processor master clock enable (high = running) |
| cpu_step | output | 1 | Single processor clock pulse |
| busy | output | 1 | A command train is in progress |

## Verification
The block samples an event at one edge, and every result shows up in the cycles after that edge. Pulse k of a train is due in cycle 1+k*(GAP+1). Busy ends one cycle after the last pulse. The clock enable changes in cycle 1. The processor reset covers cycles 1 to max(RESET_CYCLES,4). The bench drives each event at a falling edge and clears it at the next falling edge. It then compares the full output vector at every falling edge for a fixed window, against a cycle-by-cycle expectation built from those offsets. This runs over every combination of the seven events, in both run and halt. A second set of traces injects events at chosen offsets inside a train or a reset hold, to show that they are dropped or that they cancel the train.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;

    // Accepted panel command after arbitration.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_RUNHALT,
        CMD_STEP,
        CMD_EXAM,
        CMD_EXNX,
        CMD_DEP,
        CMD_DPNX
    } cmd_e;

    // One step of a command train.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LDA,
        OP_INC,
        OP_LDD,
        OP_DEP,
        OP_STEP
    } op_e;

    // Pulse outputs of the train runner.
    typedef struct packed {
        logic lda;
        logic inc;
        logic ldd;
        logic dep;
        logic step;
    } pulse_t;

    // Panel events gathered from the switch inputs.
    typedef struct packed {
        logic rst_ev;
        logic runhalt;
        logic step;
        logic exam;
        logic exnx;
        logic dep;
        logic dpnx;
    } panel_ev_t;

    localparam int MAX_STEPS = 3;
    localparam int IDX_W     = $clog2(MAX_STEPS + 1);

    // Number of pulses in the train of a command.
    function automatic logic [IDX_W-1:0] seq_len(cmd_e c);
        logic [IDX_W-1:0] n;
        case (c)
            CMD_STEP: n = IDX_W'(1);
            CMD_EXAM: n = IDX_W'(2);
            CMD_EXNX: n = IDX_W'(2);
            CMD_DEP:  n = IDX_W'(1);
            CMD_DPNX: n = IDX_W'(3);
            default:  n = '0;
        endcase
        return n;
    endfunction

    // Step i of the train of a command.
    function automatic op_e seq_op(cmd_e c, logic [IDX_W-1:0] i);
        op_e o;
        o = OP_IDLE;
        case (c)
            CMD_STEP: o = OP_STEP;
            CMD_EXAM: o = (i == '0) ? OP_LDA : OP_LDD;
            CMD_EXNX: o = (i == '0) ? OP_INC : OP_LDD;
            CMD_DEP:  o = OP_DEP;
            CMD_DPNX: begin
                if (i == IDX_W'(0))      o = OP_DEP;
                else if (i == IDX_W'(1)) o = OP_INC;
                else                     o = OP_LDD;
            end
            default:  o = OP_IDLE;
        endcase
        return o;
    endfunction

    // One-hot pulse vector for a step.
    function automatic pulse_t op_decode(op_e o);
        pulse_t p;
        p = '0;
        case (o)
            OP_LDA:  p.lda  = 1'b1;
            OP_INC:  p.inc  = 1'b1;
            OP_LDD:  p.ldd  = 1'b1;
            OP_DEP:  p.dep  = 1'b1;
            OP_STEP: p.step = 1'b1;
            default: p = '0;
        endcase
        return p;
    endfunction

    // True for commands that run a pulse train.
    function automatic logic is_train(cmd_e c);
        return (c == CMD_STEP) || (c == CMD_EXAM) || (c == CMD_EXNX) ||
               (c == CMD_DEP)  || (c == CMD_DPNX);
    endfunction

endpackage

// File: rtl/fpanel_arbiter.sv
module fpanel_arbiter
    import fpanel_pkg::*;
(
    input  panel_ev_t ev,
    input  logic      running,
    input  logic      busy,
    input  logic      holding,
    output cmd_e      pick
);

    // Priority and interlocks: reset beats all, run/halt next,
    // memory and step commands only while halted and idle.
    always_comb begin
        pick = CMD_NONE;
        if (!holding) begin
            if (ev.rst_ev) begin
                pick = CMD_RESET;
            end else if (!busy) begin
                if (ev.runhalt) begin
                    pick = CMD_RUNHALT;
                end else if (!running) begin
                    if (ev.step)      pick = CMD_STEP;
                    else if (ev.exam) pick = CMD_EXAM;
                    else if (ev.exnx) pick = CMD_EXNX;
                    else if (ev.dep)  pick = CMD_DEP;
                    else if (ev.dpnx) pick = CMD_DPNX;
                end
            end
        end
    end

endmodule

// File: rtl/fpanel_reset_hold.sv
module fpanel_reset_hold #(
    parameter int RESET_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic holding
);

    localparam int HOLD = (RESET_CYCLES < 4) ? 4 : RESET_CYCLES;
    localparam int CW   = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= CW'(HOLD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign holding = (cnt_q != '0);

endmodule

// File: rtl/fpanel_run_gate.sv
module fpanel_run_gate (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    output logic running
);

    logic run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= 1'b0;
        else if (toggle) run_q <= ~run_q;
    end

    assign running = run_q;

endmodule

// File: rtl/fpanel_step_engine.sv
module fpanel_step_engine
    import fpanel_pkg::*;
#(
    parameter int GAP = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  cmd_e   start_cmd,
    input  logic   abort,
    output pulse_t pulses,
    output logic   busy
);

    localparam int GAP_I = (GAP < 1) ? 1 : GAP;
    localparam int WW    = $clog2(GAP_I + 1);

    logic              active_q;
    cmd_e              kind_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WW-1:0]     wait_q;
    logic [IDX_W-1:0]  len;
    logic [IDX_W-1:0]  idx_nx;
    logic              at_slot;

    assign len     = seq_len(kind_q);
    assign idx_nx  = idx_q + IDX_W'(1);
    assign at_slot = active_q && (wait_q == '0) && (idx_q < len);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active_q <= 1'b0;
            kind_q   <= CMD_NONE;
            idx_q    <= '0;
            wait_q   <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                kind_q   <= start_cmd;
                idx_q    <= '0;
                wait_q   <= '0;
            end
        end else if (idx_q == len) begin
            // Tail cycle after the last pulse.
            active_q <= 1'b0;
            kind_q   <= CMD_NONE;
            idx_q    <= '0;
        end else if (wait_q == '0) begin
            idx_q  <= idx_nx;
            wait_q <= (idx_nx == len) ? '0 : WW'(GAP_I);
        end else begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign pulses = at_slot ? op_decode(seq_op(kind_q, idx_q)) : '0;
    assign busy   = active_q;

endmodule

// File: rtl/fpanel_seq.sv
module fpanel_seq
    import fpanel_pkg::*;
#(
    parameter int GAP          = 1,
    parameter int RESET_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_reset,
    input  logic ev_runhalt,
    input  logic ev_step,
    input  logic ev_exam,
    input  logic ev_exam_next,
    input  logic ev_deposit,
    input  logic ev_deposit_next,
    output logic cmd_load_addr,
    output logic cmd_inc_addr,
    output logic cmd_load_data,
    output logic cmd_deposit,
    output logic cpu_reset,
    output logic cpu_clk_en,
    output logic cpu_step,
    output logic busy
);

    panel_ev_t ev;
    cmd_e      pick;
    logic      running;
    logic      holding;
    logic      seq_busy;
    pulse_t    pulses;

    assign ev = '{rst_ev:  ev_reset,
                  runhalt: ev_runhalt,
                  step:    ev_step,
                  exam:    ev_exam,
                  exnx:    ev_exam_next,
                  dep:     ev_deposit,
                  dpnx:    ev_deposit_next};

    fpanel_arbiter u_arb (
        .ev      (ev),
        .running (running),
        .busy    (seq_busy),
        .holding (holding),
        .pick    (pick)
    );

    fpanel_reset_hold #(.RESET_CYCLES(RESET_CYCLES)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .fire    (pick == CMD_RESET),
        .holding (holding)
    );

    fpanel_run_gate u_run (
        .clk     (clk),
        .rst     (rst),
        .toggle  (pick == CMD_RUNHALT),
        .running (running)
    );

    fpanel_step_engine #(.GAP(GAP)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (is_train(pick)),
        .start_cmd (pick),
        .abort     (pick == CMD_RESET),
        .pulses    (pulses),
        .busy      (seq_busy)
    );

    assign cmd_load_addr = pulses.lda;
    assign cmd_inc_addr  = pulses.inc;
    assign cmd_load_data = pulses.ldd;
    assign cmd_deposit   = pulses.dep;
    assign cpu_step      = pulses.step;
    assign cpu_reset     = holding;
    assign cpu_clk_en    = running;
    assign busy          = seq_busy;

endmodule

// File: rtl/fpanel_seq_chk.sv
module fpanel_seq_chk (
    input logic clk,
    input logic rst,
    input logic ev_runhalt,
    input logic cmd_load_addr,
    input logic cmd_inc_addr,
    input logic cmd_load_data,
    input logic cmd_deposit,
    input logic cpu_reset,
    input logic cpu_clk_en,
    input logic cpu_step,
    input logic busy
);

    logic anyp;
    assign anyp = cmd_load_addr | cmd_inc_addr | cmd_load_data | cmd_deposit | cpu_step;

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_load_addr, cmd_inc_addr, cmd_load_data, cmd_deposit, cpu_step}));

    assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
        anyp |=> !anyp);

    assert_busy_cover_R6: assert property (@(posedge clk) disable iff (rst)
        anyp |-> busy);

    assert_toggle_src_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en != $past(cpu_clk_en)) |-> $past(ev_runhalt));

    assert_run_lock_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> !(cmd_load_addr | cmd_inc_addr | cmd_load_data | cmd_deposit));

    assert_step_halted_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_step |-> !cpu_clk_en);

    assert_hold_len_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_reset) |-> ($past(cpu_reset, 2) && $past(cpu_reset, 3) && $past(cpu_reset, 4)));

    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_reset |-> (!anyp && !busy));

endmodule

bind fpanel_seq fpanel_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_runhalt    (ev_runhalt),
    .cmd_load_addr (cmd_load_addr),
    .cmd_inc_addr  (cmd_inc_addr),
    .cmd_load_data (cmd_load_data),
    .cmd_deposit   (cmd_deposit),
    .cpu_reset     (cpu_reset),
    .cpu_clk_en    (cpu_clk_en),
    .cpu_step      (cpu_step),
    .busy          (busy)
);

// File: tb/sim_fpanel_seq.sv
module sim_fpanel_seq;

    localparam int G  = 1;
    localparam int RC = 4;
    localparam int W  = 9;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic [6:0] ev;   // [0] reset [1] run/halt [2] step [3] exam [4] exam-next [5] deposit [6] deposit-next
    logic cmd_load_addr, cmd_inc_addr, cmd_load_data, cmd_deposit;
    logic cpu_reset, cpu_clk_en, cpu_step, busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit run_model = 1'b0;

    fpanel_seq #(.GAP(G), .RESET_CYCLES(RC)) u0 (
        .clk             (clk),
        .rst             (rst),
        .ev_reset        (ev[0]),
        .ev_runhalt      (ev[1]),
        .ev_step         (ev[2]),
        .ev_exam         (ev[3]),
        .ev_exam_next    (ev[4]),
        .ev_deposit      (ev[5]),
        .ev_deposit_next (ev[6]),
        .cmd_load_addr   (cmd_load_addr),
        .cmd_inc_addr    (cmd_inc_addr),
        .cmd_load_data   (cmd_load_data),
        .cmd_deposit     (cmd_deposit),
        .cpu_reset       (cpu_reset),
        .cpu_clk_en      (cpu_clk_en),
        .cpu_step        (cpu_step),
        .busy            (busy)
    );

    // Vector: [0] lda [1] inc [2] ldd [3] dep [4] step [5] busy [6] cpu_reset [7] clk_en
    function automatic logic [7:0] observed();
        return {cpu_clk_en, cpu_reset, busy, cpu_step,
                cmd_deposit, cmd_load_data, cmd_inc_addr, cmd_load_addr};
    endfunction

    function automatic int winner(logic [6:0] m, bit run);
        if (m[0]) return 0;
        if (m[1]) return 1;
        if (run)  return -1;
        for (int b = 2; b < 7; b++) if (m[b]) return b;
        return -1;
    endfunction

    function automatic int train_len(int w);
        case (w)
            2: return 1;
            3: return 2;
            4: return 2;
            5: return 1;
            6: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] opbits(int w, int s);
        case (w)
            2: return 5'b10000;
            3: return (s == 0) ? 5'b00001 : 5'b00100;
            4: return (s == 0) ? 5'b00010 : 5'b00100;
            5: return 5'b01000;
            6: return (s == 0) ? 5'b01000 : ((s == 1) ? 5'b00010 : 5'b00100);
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [7:0] expect_at(int w, bit run, int o);
        logic [7:0] e;
        int len;
        e = '0;
        e[7] = run;
        if (w == 1) e[7] = !run;
        if (w == 0) e[6] = (o >= 1 && o <= RC);
        if (w >= 2) begin
            len = train_len(w);
            if (o >= 1 && o <= (len - 1) * (G + 1) + 2) e[5] = 1'b1;
            if (o >= 1 && ((o - 1) % (G + 1)) == 0 && ((o - 1) / (G + 1)) < len)
                e[4:0] = opbits(w, (o - 1) / (G + 1));
        end
        return e;
    endfunction

    // Deposit-next cancelled by processor reset sampled at the end of cycle 2.
    function automatic logic [7:0] expect_abort(int o);
        if (o == 1) return 8'b0010_1000;
        if (o == 2) return 8'b0010_0000;
        if (o >= 3 && o <= 2 + RC) return 8'b0100_0000;
        return 8'b0000_0000;
    endfunction

    function automatic string tag_of(int w, logic [6:0] m);
        if ($countones(m) > 1) return "R11";
        case (w)
            0: return "R10";
            1: return "R7";
            2: return "R9";
            3: return "R1";
            4: return "R2";
            5: return "R3";
            6: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag, input int o);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (pulses R5/busy R6) offset %0d: actual %b expected %b", tag, o, got, exp);
        end
    endtask

    task automatic run_trace(input logic [6:0] m1, input int at, input logic [6:0] m2,
                             input bit abort, input string tag);
        int w;
        logic [7:0] e;
        w = winner(m1, run_model);
        @(negedge clk); ev = m1;
        @(negedge clk); ev = '0;
        for (int o = 1; o <= W; o++) begin
            e = abort ? expect_abort(o) : expect_at(w, run_model, o);
            check(observed(), e, tag, o);
            ev = (o == at) ? m2 : 7'b0;
            @(negedge clk);
        end
        ev = '0;
        if (w == 1) run_model = !run_model;
    endtask

    task automatic sweep(input bit run_target);
        for (int m = 1; m < 128; m++) begin
            run_trace(7'(m), 0, 7'b0, 1'b0, tag_of(winner(7'(m), run_model), 7'(m)));
            if (run_model != run_target) run_trace(7'b0000010, 0, 7'b0, 1'b0, "R7");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ev  = '0;
        repeat (3) @(negedge clk);
        check(observed(), 8'b0, "R12", 0);
        rst = 1'b0;
        @(negedge clk);
        check(observed(), 8'b0, "R12", 0);

        // Every event combination while halted, then while running (R11, R8).
        sweep(1'b0);
        run_trace(7'b0000010, 0, 7'b0, 1'b0, "R7");
        sweep(1'b1);
        run_trace(7'b0000010, 0, 7'b0, 1'b0, "R7");

        // R6: examine during an examine-next train is dropped, not queued.
        run_trace(7'b0010000, 2, 7'b0001000, 1'b0, "R6");
        // R6/R7: run/halt during an examine train is dropped.
        run_trace(7'b0001000, 2, 7'b0000010, 1'b0, "R7");
        // R6: deposit at the tail cycle of a deposit-next train is dropped.
        run_trace(7'b1000000, 6, 7'b0100000, 1'b0, "R6");
        // R10: processor reset cancels a deposit-next train.
        run_trace(7'b1000000, 2, 7'b0000001, 1'b1, "R10");
        // R10: events during the reset hold are ignored.
        run_trace(7'b0000001, 2, 7'b0001000, 1'b0, "R10");
        run_trace(7'b0000001, 3, 7'b0000011, 1'b0, "R10");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule